// File: doc/BRIEF.md
# Flash Rewrite Mode Control Register

This block is a CPU-visible control and status register. It decides when an on-chip flash controller may be reprogrammed by the running processor. Software arms a rewrite mode through a guarded two-write sequence. The mode is only entered while an external enable pin is also high. Once the mode is entered, processor writes to the flash address space pass to the flash controller, but only at even addresses. A reset bit in the same register lets software hold the flash control circuit in reset. A ready/busy flag reports what the flash controller is doing.

The register sits at one bus address, `CTRL_ADDR`. A bus write to any other address counts as a flash command or data write. Such a write is forwarded in the same cycle when the conditions allow it. Register reads are combinational.

Register layout, low byte: bit 0 = ready (read-only), bit 1 = mode select, bit 2 = mode entered (read-only), bit 3 = flash controller reset. Every other bit of the data bus reads as 0.

Top module: `flash_rw_ctl`

## Requirements
- R1: After reset, the select, entered and reset bits are 0, `fc_rst` and `cmd_we` are low, and a register read with the flash idle returns 0x0001.
- R2: Bit 1 becomes 1 only from a register write with bit 1 = 1 whose previous register access was a write with bit 1 = 0. Any register read or other register write in between cancels the arming.
- R3: A register write with bit 1 = 0 clears bit 1 at once. A write with bit 1 = 1 that is not armed leaves bit 1 unchanged.
- R4: Bit 2 reads 1 from the second cycle after the select write, provided `mode_pin` is high. It clears on the clock after `mode_pin` or bit 1 drops. Dropping `mode_pin` leaves bit 1 unchanged.
- R5: Bit 0 reads the inverse of `fc_busy` in the same cycle: 0 while busy, 1 while idle.
- R6: A write with bit 3 = 1 while bit 1 is already 1 sets bit 3 and raises `fc_rst` on the next cycle. With bit 1 at 0, the same write has no effect. Bit 3 stays set until a write with bit 3 = 0, even if bit 1 is cleared.
- R7: While bit 2 is 1, a bus write to a non-register address with A0 = 0 drives `cmd_we` high in the same cycle, carrying that address and the 16-bit data. Writes to odd addresses, and any write while bit 2 is 0, are dropped.
- R8: Writes to bits 0 and 2 and to bits 4 and above have no effect. Register bits 4 and above always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mode_pin | input | 1 | External rewrite-mode enable |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | DATA_W | Bus write data |
| rdata | output | DATA_W | Register read data, 0 when the register is not read |
| fc_busy | input | 1 | Flash controller busy with program or erase |
| fc_rst | output | 1 | Reset to the flash control circuit |
| cmd_we | output | 1 | Forwarded command/data write strobe |
| cmd_addr | output | ADDR_W | Forwarded address |
| cmd_data | output | DATA_W | Forwarded command/data word |

## Verification
Some results are due in the same cycle as their stimulus: the read data, the ready bit and the forwarded write. Their checks drive the bus half a period before the edge and sample one time unit later. The select and reset bits change at the edge that takes the write, so the first read after it already shows them. The entered flag follows the select bit one edge later. The stimulus table therefore expects select=1, entered=0 on the first read after the arming write and entered=1 on the second. The pin-drop and clear cases are likewise checked one clock after the change.

// File: rtl/flash_rw_ctl.sv
module flash_rw_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              fc_busy,
  output logic              fc_rst,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int PAD_W = DATA_W - 4;

  logic hit, reg_wr, reg_rd, reg_acc;
  logic sel_q, ent_q, rst_q, armed_q;

  assign hit     = (addr == CTRL_ADDR);
  assign reg_wr  = wr_en & hit;
  assign reg_rd  = rd_en & hit;
  assign reg_acc = reg_wr | reg_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      ent_q   <= 1'b0;
      rst_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ent_q <= sel_q & mode_pin;
      if (reg_acc)
        armed_q <= reg_wr & ~wdata[1];
      if (reg_wr) begin
        if (!wdata[1])
          sel_q <= 1'b0;
        else if (armed_q)
          sel_q <= 1'b1;
        if (!wdata[3])
          rst_q <= 1'b0;
        else if (sel_q)
          rst_q <= 1'b1;
      end
    end
  end

  assign fc_rst   = rst_q;
  assign rdata    = reg_rd ? {{PAD_W{1'b0}}, rst_q, ent_q, sel_q, ~fc_busy} : '0;
  assign cmd_we   = wr_en & ~hit & ~addr[0] & ent_q;
  assign cmd_addr = addr;
  assign cmd_data = wdata;

  p_sel_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(reg_wr && wdata[1] && armed_q));

  p_sel_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wdata[1]) |=> !sel_q);

  p_ent_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_q |-> $past(sel_q && mode_pin));

  p_pin_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pin |=> !ent_q);

  p_rst_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc_rst) |-> $past(sel_q));

  p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_rst && !(reg_wr && !wdata[3])) |=> fc_rst);

  p_fwd_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> (!cmd_addr[0] && ent_q && !hit));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (rdata[DATA_W-1:4] == '0));

endmodule

// File: tb/flash_rw_ctl_tb_top.sv
module flash_rw_ctl_tb_top;
  localparam logic [15:0] CA = 16'h0040;

  logic clk = 0, rst_n = 0, mode_pin = 0, wr_en = 0, rd_en = 0, fc_busy = 0;
  logic [15:0] addr = 0, wdata = 0;
  logic [15:0] rdata, cmd_addr, cmd_data;
  logic fc_rst, cmd_we;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_rw_ctl #(.ADDR_W(16), .DATA_W(16), .CTRL_ADDR(CA)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .fc_busy(fc_busy), .fc_rst(fc_rst),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  // entry: {is_write, data[7:0], expected bits[3:0] on read, requirement number}
  localparam int NV = 24;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 4'h1, 4'd1},  // R1 idle read
    {1'b1, 8'h02, 4'h0, 4'd3},  // R3 unarmed set
    {1'b0, 8'h00, 4'h1, 4'd3},
    {1'b1, 8'h00, 4'h0, 4'd2},  // R2 arm
    {1'b1, 8'h02, 4'h0, 4'd2},
    {1'b0, 8'h00, 4'h3, 4'd4},  // R4 entered lags one cycle
    {1'b0, 8'h00, 4'h7, 4'd4},
    {1'b1, 8'h0A, 4'h0, 4'd6},  // R6 reset while selected
    {1'b0, 8'h00, 4'hF, 4'd6},
    {1'b1, 8'h06, 4'h0, 4'd8},  // R8 bit2 write ignored
    {1'b0, 8'h00, 4'h7, 4'd8},
    {1'b1, 8'h00, 4'h0, 4'd3},  // R3 clear
    {1'b0, 8'h00, 4'h5, 4'd4},
    {1'b0, 8'h00, 4'h1, 4'd3},
    {1'b1, 8'h08, 4'h0, 4'd6},  // R6 reset ignored when not selected
    {1'b0, 8'h00, 4'h1, 4'd6},
    {1'b1, 8'h00, 4'h0, 4'd2},  // R2 read breaks arming
    {1'b0, 8'h00, 4'h1, 4'd2},
    {1'b1, 8'h02, 4'h0, 4'd2},
    {1'b0, 8'h00, 4'h1, 4'd2},
    {1'b1, 8'h00, 4'h0, 4'd2},
    {1'b1, 8'hF2, 4'h0, 4'd8},  // R8 upper bits ignored
    {1'b0, 8'h00, 4'h3, 4'd8},
    {1'b0, 8'h00, 4'h7, 4'd4}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic reg_write(input logic [15:0] d);
    wr_en = 1; addr = CA; wdata = d;
    step();
  endtask

  task automatic reg_read(input string req, input logic [15:0] exp);
    rd_en = 1; addr = CA;
    #1 chk(req, rdata, exp);
    step();
  endtask

  task automatic bus_write(input string req, input logic [15:0] a, input logic [15:0] d,
                           input logic exp_we);
    wr_en = 1; addr = a; wdata = d;
    #1;
    chk(req, {15'b0, cmd_we}, {15'b0, exp_we});
    if (exp_we) begin
      chk(req, cmd_addr, a);
      chk(req, cmd_data, d);
    end
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", {14'b0, fc_rst, cmd_we}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    mode_pin = 1;
    reg_read("R1", 16'h0001);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) reg_write({8'h00, VEC[i][15:8]});
      else reg_read($sformatf("R%0d vec%0d", VEC[i][3:0], i), {12'h000, VEC[i][7:4]});
    end

    // R5 busy flag
    fc_busy = 1;
    reg_read("R5", 16'h0006);
    fc_busy = 0;
    reg_read("R5", 16'h0007);

    // R7 forwarding
    bus_write("R7 even", 16'h1000, 16'h00A5, 1'b1);
    bus_write("R7 odd", 16'h1001, 16'h0070, 1'b0);
    bus_write("R7 reg addr", CA, 16'h0002, 1'b0);

    // R4 pin drop keeps select
    mode_pin = 0;
    step();
    reg_read("R4", 16'h0003);
    bus_write("R7 not entered", 16'h2000, 16'h0040, 1'b0);

    // R6 persistence
    reg_write(16'h000A);
    chk("R6 set", {15'b0, fc_rst}, 16'h1);
    reg_write(16'h0008);
    chk("R6 hold", {15'b0, fc_rst}, 16'h1);
    reg_read("R6", 16'h0009);
    reg_write(16'h0000);
    chk("R6 release", {15'b0, fc_rst}, 16'h0);
    reg_write(16'h0008);
    chk("R6 unselected", {15'b0, fc_rst}, 16'h0);

    // R1 mid-run reset
    mode_pin = 1;
    reg_write(16'h0000);
    reg_write(16'h0002);
    reg_write(16'h000A);
    rst_n = 0;
    #1 chk("R1 async", {15'b0, fc_rst}, 16'h0);
    step();
    rst_n = 1;
    @(negedge clk);
    reg_read("R1 after", 16'h0001);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule